// File: doc/BRIEF.md
# Debug Configuration and Peripheral Freeze Controller

This block is a small register file on a 32-bit register bus that a debugger or software programs to control how the chip behaves while the processor is halted or asleep. It has four words. The first is a fixed identity word. The second is a low-power configuration word that keeps the core and bus clocks alive in the two deep-sleep modes. The last two are freeze-enable masks, one for peripherals on the low-speed bus and one for peripherals on the high-speed bus.

Each freeze output is one registered bit. It is the product of a stored enable and the processor's live halt status. Timers, watchdogs, the real-time counter, a bus timeout and a CAN controller use these bits to stop counting while a debugger examines the halted core. The stored state belongs to the power-on reset domain only. A system reset neither clears it nor blocks writes to it, so a debugger can set the block up while the rest of the chip is held in reset.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: The word at offset 0x00 reads as {REV_ID[15:0], 4'b0110, DEV_ID[11:0]}. With the default parameters this is 0x200164A7. Writes to it have no effect and complete without error.
- R2: The register index is taken from address bits [3:2], and address bits [1:0] are ignored. The configuration word (index 1) stores only bits 1 and 2. The low-speed freeze word (index 2) stores only bits 0, 1, 4, 5, 8, 10, 11, 12, 21 and 25, which is mask 0x02201D33. The high-speed freeze word (index 3) stores only bits 11, 16, 17 and 18, which is mask 0x00070800. All other bits read 0 and ignore writes.
- R3: Driving por_n low clears the configuration word, both freeze words, every freeze output and the response outputs.
- R4: The level of sys_rst_n never changes stored values. Writes made while sys_rst_n is low take effect as usual.
- R5: req_size_i encodes 0 = byte, 1 = half-word, 2 = word and 3 = reserved. A request whose size is not 2 gets resp_err_o = 1 and resp_rdata_o = 0, and leaves every register unchanged.
- R6: A request seen on a clock edge gives resp_valid_o high for exactly the following cycle. A word access responds with resp_err_o = 0. A word write responds with resp_rdata_o = 0.
- R7: Bit i of frz_lo_o becomes (stored low-speed enable bit i AND core_halted_i) at the clock edge after those inputs hold. It drops at the edge after the halt clears.
- R8: frz_hi_o follows the same registered rule as R7, using the high-speed freeze word.
- R9: keep_clk_o is combinational and equals (configuration bit 1 AND stop_mode_i) OR (configuration bit 2 AND standby_mode_i).
- R10: stby_rst_req_o is combinational and equals configuration bit 2 AND standby_mode_i. It requests a system reset during Standby, so that waking from Standby behaves like a normal reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; does not affect this block |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_size_i | input | 2 | Access size code (2 = word) |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| resp_err_o | output | 1 | Error response for a size other than word |
| resp_rdata_o | output | 32 | Read data |
| core_halted_i | input | 1 | Processor halted by debug |
| stop_mode_i | input | 1 | Chip is in Stop mode |
| standby_mode_i | input | 1 | Chip is in Standby mode |
| frz_lo_o | output | 32 | Freeze bits for low-speed-bus peripherals |
| frz_hi_o | output | 32 | Freeze bits for high-speed-bus peripherals |
| keep_clk_o | output | 1 | Keep core and bus clocks on from the internal RC oscillator |
| stby_rst_req_o | output | 1 | System reset request while in Standby |

## Verification
The bench sweeps every register index against several data patterns. It sends every non-word size code to every writable register, walks a single enable bit across all 32 positions of both freeze words while the core is halted, and tries all sixteen combinations of the configuration bits and the two mode inputs.

Each sweep targets a specific fault:
- A decoder that kept reserved bits would read back pattern bits outside the masks.
- A size check that fell through would overwrite a register or return no error.
- A freeze path without its register would change in the same cycle as the halt input instead of one edge later, and would not drop one edge after the halt clears.
- Tying the stored words to system reset would lose values across a sys_rst_n pulse and would reject the writes made while it was low.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
   localparam int unsigned DATA_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      IDX_IDENT = 2'd0,
      IDX_CFG   = 2'd1,
      IDX_FZLO  = 2'd2,
      IDX_FZHI  = 2'd3
   } reg_idx_e;

   localparam int unsigned CFG_STOP_BIT = 1;
   localparam int unsigned CFG_STBY_BIT = 2;
   localparam logic [DATA_W-1:0] CFG_MASK =
      (32'd1 << CFG_STOP_BIT) | (32'd1 << CFG_STBY_BIT);
   localparam logic [3:0] IDENT_FIXED = 4'b0110;
endpackage

// File: rtl/dbgf_regbank.sv
module dbgf_regbank
   import dbgf_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter logic [11:0] DEV_ID  = 12'h4A7,
   parameter logic [15:0] REV_ID  = 16'h2001,
   parameter logic [31:0] LO_MASK = 32'h0220_1D33,
   parameter logic [31:0] HI_MASK = 32'h0007_0800
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_size_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              resp_valid_o,
   output logic              resp_err_o,
   output logic [DATA_W-1:0] resp_rdata_o,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] fzlo_o,
   output logic [DATA_W-1:0] fzhi_o
);
   localparam logic [DATA_W-1:0] IDENT_WORD = {REV_ID, IDENT_FIXED, DEV_ID};
   localparam int unsigned NUM_RW = 3;

   function automatic logic [DATA_W-1:0] wmask(input int unsigned k);
      case (k)
         1:       return CFG_MASK;
         2:       return LO_MASK;
         3:       return HI_MASK;
         default: return '0;
      endcase
   endfunction

   reg_idx_e          idx;
   size_e             size;
   logic              word_ok;
   logic              wr_fire;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rw_q [1:NUM_RW];
   logic              unused_addr_bits;
   logic              unused_sysrst;

   assign idx     = reg_idx_e'(req_addr_i[3:2]);
   assign size    = size_e'(req_size_i);
   assign word_ok = (size == SZ_WORD);
   assign wr_fire = req_valid_i && req_write_i && word_ok;

   generate
      if (ADDR_W > 4) begin : g_wide_addr
         assign unused_addr_bits = ^{req_addr_i[ADDR_W-1:4], req_addr_i[1:0]};
      end else begin : g_narrow_addr
         assign unused_addr_bits = ^req_addr_i[1:0];
      end
   endgenerate
   assign unused_sysrst = sys_rst_n;

   // Writable words live in the power-on domain only.
   for (genvar g = 1; g <= NUM_RW; g++) begin : g_rw
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            rw_q[g] <= '0;
         else if (wr_fire && (int'(idx) == g))
            rw_q[g] <= req_wdata_i & wmask(g);
      end
   end

   always_comb begin
      case (idx)
         IDX_IDENT: rd_mux = IDENT_WORD;
         IDX_CFG:   rd_mux = rw_q[1];
         IDX_FZLO:  rd_mux = rw_q[2];
         default:   rd_mux = rw_q[3];
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         resp_valid_o <= 1'b0;
         resp_err_o   <= 1'b0;
         resp_rdata_o <= '0;
      end else begin
         resp_valid_o <= req_valid_i;
         resp_err_o   <= req_valid_i && !word_ok;
         resp_rdata_o <= (req_valid_i && word_ok && !req_write_i) ? rd_mux : '0;
      end
   end

   assign cfg_o  = rw_q[1];
   assign fzlo_o = rw_q[2];
   assign fzhi_o = rw_q[3];

   AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!por_n)
      req_valid_i |=> resp_valid_o); // R6
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!por_n)
      !req_valid_i |=> !resp_valid_o); // R6
   AST_BADSIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
      (req_valid_i && req_size_i != 2'd2) |=>
         ($stable(rw_q[1]) && $stable(rw_q[2]) && $stable(rw_q[3]))); // R5
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!por_n)
      (resp_valid_o && resp_err_o) |-> (resp_rdata_o == '0)); // R5
   AST_IDENT_NIBBLE: assert property (@(posedge clk) disable iff (!por_n)
      (req_valid_i && !req_write_i && req_size_i == 2'd2 && req_addr_i[3:2] == 2'd0)
         |=> (resp_rdata_o[15:12] == 4'b0110)); // R1
   AST_SYSRST_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && !(req_valid_i && req_write_i)) |=>
         ($stable(rw_q[1]) && $stable(rw_q[2]) && $stable(rw_q[3]))); // R4
endmodule

// File: rtl/dbgf_freeze_gate.sv
module dbgf_freeze_gate
   import dbgf_pkg::*;
#(
   parameter logic [31:0] MASK = 32'h0000_0001
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              halted_i,
   input  logic [DATA_W-1:0] en_i,
   output logic [DATA_W-1:0] frz_o
);
   logic unused_en;
   assign unused_en = ^(en_i & ~MASK);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) frz_o[i] <= 1'b0;
            else        frz_o[i] <= en_i[i] & halted_i;
         end
      end else begin : g_tie
         assign frz_o[i] = 1'b0;
      end
   end

   AST_FRZ_NEEDS_HALT: assert property (@(posedge clk) disable iff (!por_n)
      (|frz_o) |-> $past(halted_i)); // R7
   AST_FRZ_DROPS: assert property (@(posedge clk) disable iff (!por_n)
      !halted_i |=> (frz_o == '0)); // R8
endmodule

// File: rtl/dbgf_lp_ctrl.sv
module dbgf_lp_ctrl (
   input  logic stop_keep_i,
   input  logic stby_keep_i,
   input  logic stop_mode_i,
   input  logic standby_mode_i,
   output logic keep_clk_o,
   output logic stby_rst_req_o
);
   logic stop_req;
   logic stby_req;

   assign stop_req       = stop_keep_i & stop_mode_i;
   assign stby_req       = stby_keep_i & standby_mode_i;
   assign keep_clk_o     = stop_req | stby_req;
   assign stby_rst_req_o = stby_req;

   always_comb begin
      AST_RSTREQ_KEEPS_CLK: assert (!stby_rst_req_o || keep_clk_o); // R10
      AST_KEEP_NEEDS_MODE: assert (!keep_clk_o || stop_mode_i || standby_mode_i); // R9
   end
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
   import dbgf_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter logic [11:0] DEV_ID  = 12'h4A7,
   parameter logic [15:0] REV_ID  = 16'h2001,
   parameter logic [31:0] LO_MASK = 32'h0220_1D33,
   parameter logic [31:0] HI_MASK = 32'h0007_0800
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [1:0]        req_size_i,
   input  logic [31:0]       req_wdata_i,
   output logic              resp_valid_o,
   output logic              resp_err_o,
   output logic [31:0]       resp_rdata_o,
   input  logic              core_halted_i,
   input  logic              stop_mode_i,
   input  logic              standby_mode_i,
   output logic [31:0]       frz_lo_o,
   output logic [31:0]       frz_hi_o,
   output logic              keep_clk_o,
   output logic              stby_rst_req_o
);
   generate
      if (ADDR_W < 4) begin : g_chk_addr
         $error("ADDR_W must cover four word offsets");
      end
      if (LO_MASK == '0 || HI_MASK == '0) begin : g_chk_mask
         $error("freeze masks must select at least one bit");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_w;
   logic [DATA_W-1:0] fzlo_w;
   logic [DATA_W-1:0] fzhi_w;

   dbgf_regbank #(
      .ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .REV_ID(REV_ID),
      .LO_MASK(LO_MASK), .HI_MASK(HI_MASK)
   ) u_regs (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_addr_i(req_addr_i), .req_size_i(req_size_i),
      .req_wdata_i(req_wdata_i),
      .resp_valid_o(resp_valid_o), .resp_err_o(resp_err_o),
      .resp_rdata_o(resp_rdata_o),
      .cfg_o(cfg_w), .fzlo_o(fzlo_w), .fzhi_o(fzhi_w)
   );

   dbgf_freeze_gate #(.MASK(LO_MASK)) u_frz_lo (
      .clk(clk), .por_n(por_n), .halted_i(core_halted_i),
      .en_i(fzlo_w), .frz_o(frz_lo_o)
   );

   dbgf_freeze_gate #(.MASK(HI_MASK)) u_frz_hi (
      .clk(clk), .por_n(por_n), .halted_i(core_halted_i),
      .en_i(fzhi_w), .frz_o(frz_hi_o)
   );

   logic unused_cfg;
   assign unused_cfg = ^(cfg_w & ~CFG_MASK);

   dbgf_lp_ctrl u_lp (
      .stop_keep_i(cfg_w[CFG_STOP_BIT]),
      .stby_keep_i(cfg_w[CFG_STBY_BIT]),
      .stop_mode_i(stop_mode_i),
      .standby_mode_i(standby_mode_i),
      .keep_clk_o(keep_clk_o),
      .stby_rst_req_o(stby_rst_req_o)
   );
endmodule

// File: tb/tb_dbg_freeze_ctrl.sv
module tb_dbg_freeze_ctrl;
   localparam logic [31:0] ID_EXP  = 32'h2001_64A7;
   localparam logic [31:0] CFG_M   = 32'h0000_0006;
   localparam logic [31:0] LO_M    = 32'h0220_1D33;
   localparam logic [31:0] HI_M    = 32'h0007_0800;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, sys_rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic        resp_valid, resp_err;
   logic [31:0] resp_rdata, frz_lo, frz_hi;
   logic        halted = 1'b0, stop_m = 1'b0, stby_m = 1'b0;
   logic        keep_clk, rst_req;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   dbg_freeze_ctrl dut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
      .resp_valid_o(resp_valid), .resp_err_o(resp_err), .resp_rdata_o(resp_rdata),
      .core_halted_i(halted), .stop_mode_i(stop_m), .standby_mode_i(stby_m),
      .frz_lo_o(frz_lo), .frz_hi_o(frz_hi),
      .keep_clk_o(keep_clk), .stby_rst_req_o(rst_req)
   );

   function automatic logic [31:0] mask_of(input int k);
      case (k)
         1: return CFG_M;
         2: return LO_M;
         3: return HI_M;
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus(input logic wr, input int idx, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic er, output logic rv);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 4'(idx << 2) | 4'(idx & 3);
      req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      rv = resp_valid; rd = resp_rdata; er = resp_err;
   endtask

   task automatic rd_word(input int idx, input logic [31:0] exp, input string tag);
      logic [31:0] d; logic e, v;
      bus(1'b0, idx, 2'd2, '0, d, e, v);
      chk({tag, " data"}, d, exp);
      chk("R6 valid/err", {30'd0, v, e}, 32'd2);
   endtask

   task automatic wr_word(input int idx, input logic [31:0] wd);
      logic [31:0] d; logic e, v;
      bus(1'b1, idx, 2'd2, wd, d, e, v);
      chk("R6 write resp", {d[29:0], v, e}, 32'd2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pats [4];
      logic [31:0] d; logic e, v;
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R3: reset state (sys_rst_n still low)
      chk("R3 frz_lo", frz_lo, '0);
      chk("R3 frz_hi", frz_hi, '0);
      chk("R3 resp", {30'd0, resp_valid, resp_err}, '0);
      rd_word(0, ID_EXP, "R1 ident");
      for (int k = 1; k < 4; k++) rd_word(k, '0, "R3 cleared");

      // R2/R1/R4: pattern sweep, first half with system reset held
      for (int p = 0; p < 4; p++) begin
         if (p == 2) sys_rst_n = 1'b1;
         for (int k = 0; k < 4; k++) begin
            wr_word(k, pats[p]);
            rd_word(k, (k == 0) ? ID_EXP : (pats[p] & mask_of(k)),
                    (k == 0) ? "R1 ident write ignored" : "R2 R4 masked store");
         end
      end

      // R4: system reset pulse keeps contents
      for (int k = 1; k < 4; k++) wr_word(k, 32'hFFFF_FFFF);
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (3) @(negedge clk); sys_rst_n = 1'b1;
      for (int k = 1; k < 4; k++) rd_word(k, mask_of(k), "R4 survives sys reset");

      // R5: non-word sizes
      for (int k = 1; k < 4; k++) begin
         for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            bus(1'b1, k, 2'(s), 32'h0, d, e, v);
            chk("R5 write err", {30'd0, v, e}, 32'd3);
            chk("R5 err data", d, '0);
            bus(1'b0, k, 2'(s), 32'h0, d, e, v);
            chk("R5 read err", {d[29:0], v, e}, 32'd3);
            rd_word(k, mask_of(k), "R5 unchanged");
         end
      end

      // R7/R8: halt timing
      @(negedge clk); halted = 1'b1;
      chk("R7 no change before edge", frz_lo, '0);
      @(negedge clk);
      chk("R7 frz_lo on halt", frz_lo, LO_M);
      chk("R8 frz_hi on halt", frz_hi, HI_M);
      halted = 1'b0;
      chk("R7 holds until edge", frz_lo, LO_M);
      @(negedge clk);
      chk("R7 frz_lo released", frz_lo, '0);
      chk("R8 frz_hi released", frz_hi, '0);

      // R7/R8: walking enable bit while halted
      halted = 1'b1;
      for (int b = 0; b < 32; b++) begin
         wr_word(2, 32'd1 << b);
         wr_word(3, 32'd1 << b);
         @(negedge clk);
         chk("R7 walk", frz_lo, (32'd1 << b) & LO_M);
         chk("R8 walk", frz_hi, (32'd1 << b) & HI_M);
      end
      halted = 1'b0;
      @(negedge clk);
      chk("R8 walk release", frz_lo | frz_hi, '0);

      // R9/R10: low-power combinations
      for (int c = 0; c < 4; c++) begin
         wr_word(1, 32'(c) << 1);
         for (int m = 0; m < 4; m++) begin
            stop_m = m[0]; stby_m = m[1];
            #1;
            chk("R9 keep_clk", {31'd0, keep_clk},
                {31'd0, (c[0] & m[0]) | (c[1] & m[1])});
            chk("R10 stby_rst_req", {31'd0, rst_req}, {31'd0, c[1] & m[1]});
         end
      end
      stop_m = 1'b0; stby_m = 1'b0;

      // R3: power-on reset clears again
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      for (int k = 1; k < 4; k++) rd_word(k, '0, "R3 por clears");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule